// File: doc/BRIEF.md
# Shiftable-Window SAD Search Engine

This block scores a block-matching search. It holds a 16x16 block of current pixels and a 16x16 reference window. It produces the sum of absolute differences (SAD) over all 256 pixel pairs for each candidate alignment it is asked to evaluate. Both pixel stores present every row at once, so the whole block reaches the datapath in the same cycle. The 256 differences fold into one sum through a two-stage adder tree. No partial results are kept outside the tree.

The reference store can move its whole contents by one pixel up, down, left or right in one cycle, taking in a fresh row or column at the edge that was vacated. A controller can therefore evaluate in one cycle and shift in the same cycle, and score a new alignment on every clock without reloading the window. The block follows the displacement that the shifts build up. It keeps the smallest SAD seen since the last start pulse, with its signed x/y offset. Memory fetch and the choice of search path belong to the controller.

Top module: `sad_search_engine`

## Requirements
- R1: After reset all pixels are zero, and `sad_valid` and `best_valid` are low.
- R2: A cycle with `eval` high scores the store contents held before that cycle's edge. `sad_valid` rises two cycles later with `sad_value` equal to the sum over r,c of |cur(r,c) - ref(r,c)|. Pixel c of a row vector is at bits [8c+7:8c].
- R3: `sad_value` covers the full range: 256 pairs of 0 against 255 give 65280.
- R4: A shift with direction code 0 (up) moves each reference row r+1 into row r. The fill vector enters row 15.
- R5: Direction code 1 (down) moves each row r into row r+1. The fill vector enters row 0.
- R6: Direction code 2 (left) moves column c+1 into column c. Fill pixel r enters row r, column 15.
- R7: Direction code 3 (right) moves column c into column c+1. Fill pixel r enters row r, column 0.
- R8: `start` sets the offset to (0,0). Up adds 1 to y, down subtracts 1 from y, left adds 1 to x and right subtracts 1 from x. `sad_dx`/`sad_dy` report the offset at the evaluation cycle, before that cycle's shift.
- R9: `best_sad`/`best_dx`/`best_dy` keep the smallest SAD reported since `start`. On equal SADs the earlier candidate stays.
- R10: `start` clears `best_valid` and drops results still in the tree. An `eval` in the start cycle belongs to the new search with offset (0,0).
- R11: A reference row write in a cycle that also shifts is ignored.
- R12: `cur_wr_en` and `ref_wr_en` each load the addressed row with the given vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_wr_en | input | 1 | Write a row of the current block |
| cur_wr_row | input | 4 | Row index for the current-block write |
| cur_wr_data | input | 128 | Row pixels, pixel c at [8c+7:8c] |
| ref_wr_en | input | 1 | Write a row of the reference window |
| ref_wr_row | input | 4 | Row index for the reference write |
| ref_wr_data | input | 128 | Row pixels for the reference write |
| sh_en | input | 1 | Shift the reference window this cycle |
| sh_dir | input | 2 | 0 up, 1 down, 2 left, 3 right |
| sh_fill | input | 128 | Pixels entering the vacated row or column |
| eval | input | 1 | Score the current alignment |
| start | input | 1 | Begin a new search |
| sad_valid | output | 1 | A SAD result is present |
| sad_value | output | 16 | SAD of the candidate |
| sad_dx | output | 8 | Signed x offset of the candidate |
| sad_dy | output | 8 | Signed y offset of the candidate |
| best_valid | output | 1 | At least one candidate since start |
| best_sad | output | 16 | Smallest SAD so far |
| best_dx | output | 8 | Signed x offset of the best candidate |
| best_dy | output | 8 | Signed y offset of the best candidate |

## Verification
The hardest situations to reach are the ones where control events overlap in a single cycle. One is a `start` arriving while an older result is still inside the two-stage tree. Another is an evaluation, a shift and a row write landing on the same edge. The stimulus lines these up deliberately. It issues an `eval` and then a bare `start` on the next cycle, then a `start` together with `eval` after a nonzero offset has built up, and a shift that carries a write to a different row. A window of uniform pixels gives equal SADs at different offsets, which reaches the tie rule.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [1:0] {
    SH_UP    = 2'd0,
    SH_DOWN  = 2'd1,
    SH_LEFT  = 2'd2,
    SH_RIGHT = 2'd3
  } shift_dir_t;
endpackage

// File: rtl/sad_cur_store.sv
module sad_cur_store #(
  parameter int N     = 16,
  parameter int PIX_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(N)-1:0]     wr_row,
  input  logic [N*PIX_W-1:0]       wr_data,
  output logic [N*N*PIX_W-1:0]     pix_flat
);
  logic [N-1:0][N*PIX_W-1:0] rows_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     rows_q <= '0;
    else if (wr_en) rows_q[wr_row] <= wr_data;
  end

  assign pix_flat = rows_q;

  // R12
  row_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rows_q[$past(wr_row)] == $past(wr_data));
endmodule

// File: rtl/sad_ref_shifter.sv
module sad_ref_shifter
  import sad_pkg::*;
#(
  parameter int N     = 16,
  parameter int PIX_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(N)-1:0]     wr_row,
  input  logic [N*PIX_W-1:0]       wr_data,
  input  logic                     sh_en,
  input  shift_dir_t               sh_dir,
  input  logic [N*PIX_W-1:0]       sh_fill,
  output logic [N*N*PIX_W-1:0]     pix_flat
);
  logic [N-1:0][N-1:0][PIX_W-1:0] win_q, win_d;
  logic [N-1:0][PIX_W-1:0]        fill_v;
  logic                           wr_taken;

  assign fill_v   = sh_fill;
  assign wr_taken = wr_en && !sh_en;

  always_comb begin
    win_d = win_q;
    if (sh_en) begin
      for (int r = 0; r < N; r++) begin
        for (int c = 0; c < N; c++) begin
          case (sh_dir)
            SH_UP:    win_d[r][c] = (r == N-1) ? fill_v[c] : win_q[(r+1)%N][c];
            SH_DOWN:  win_d[r][c] = (r == 0)   ? fill_v[c] : win_q[(r+N-1)%N][c];
            SH_LEFT:  win_d[r][c] = (c == N-1) ? fill_v[r] : win_q[r][(c+1)%N];
            default:  win_d[r][c] = (c == 0)   ? fill_v[r] : win_q[r][(c+N-1)%N];
          endcase
        end
      end
    end else if (wr_taken) begin
      win_d[wr_row] = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  assign pix_flat = win_q;

  // R4
  shift_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_en && sh_dir == SH_UP) |=> (win_q[N-1] == $past(sh_fill)) && (win_q[0] == $past(win_q[1])));
  // R5
  shift_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_en && sh_dir == SH_DOWN) |=> (win_q[0] == $past(sh_fill)) && (win_q[1] == $past(win_q[0])));
  // R6
  shift_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_en && sh_dir == SH_LEFT) |=> (win_q[0][N-1] == $past(fill_v[0])) && (win_q[0][0] == $past(win_q[0][1])));
  // R7
  shift_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_en && sh_dir == SH_RIGHT) |=> (win_q[N-1][0] == $past(fill_v[N-1])) && (win_q[0][1] == $past(win_q[0][0])));
  // R11
  write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sh_en && sh_dir == SH_UP) |=> win_q[N-1] == $past(sh_fill));
endmodule

// File: rtl/sad_tree.sv
module sad_tree #(
  parameter int N     = 16,
  parameter int PIX_W = 8,
  parameter int OFF_W = 8,
  localparam int RS_W  = PIX_W + $clog2(N),
  localparam int SAD_W = PIX_W + 2*$clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     eval,
  input  logic                     flush,
  input  logic [N*N*PIX_W-1:0]     cur_flat,
  input  logic [N*N*PIX_W-1:0]     ref_flat,
  input  logic signed [OFF_W-1:0]  tag_dx,
  input  logic signed [OFF_W-1:0]  tag_dy,
  output logic                     out_valid,
  output logic [SAD_W-1:0]         out_sad,
  output logic signed [OFF_W-1:0]  out_dx,
  output logic signed [OFF_W-1:0]  out_dy
);
  function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [RS_W-1:0] row_sad(input logic [N*PIX_W-1:0] ra, input logic [N*PIX_W-1:0] rb);
    logic [RS_W-1:0] acc;
    acc = '0;
    for (int c = 0; c < N; c++)
      acc = acc + RS_W'(abs_diff(ra[c*PIX_W +: PIX_W], rb[c*PIX_W +: PIX_W]));
    return acc;
  endfunction

  logic [N-1:0][RS_W-1:0] rs_d, rs_q;
  logic                   v1_q;
  logic signed [OFF_W-1:0] dx1_q, dy1_q;
  logic [SAD_W-1:0]       total_d;

  for (genvar r = 0; r < N; r++) begin : g_row
    assign rs_d[r] = row_sad(cur_flat[r*N*PIX_W +: N*PIX_W], ref_flat[r*N*PIX_W +: N*PIX_W]);
  end

  always_comb begin
    total_d = '0;
    for (int r = 0; r < N; r++) total_d = total_d + SAD_W'(rs_q[r]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_q <= '0; v1_q <= 1'b0; dx1_q <= '0; dy1_q <= '0;
      out_valid <= 1'b0; out_sad <= '0; out_dx <= '0; out_dy <= '0;
    end else begin
      v1_q  <= eval;
      if (eval) begin
        rs_q  <= rs_d;
        dx1_q <= tag_dx;
        dy1_q <= tag_dy;
      end
      out_valid <= v1_q && !flush;
      if (v1_q) begin
        out_sad <= total_d;
        out_dx  <= dx1_q;
        out_dy  <= dy1_q;
      end
    end
  end

  // R3
  sad_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sad <= SAD_W'(N*N*((1 << PIX_W) - 1)));
  // R2
  stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(v1_q));
  // R10
  flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
endmodule

// File: rtl/sad_best_tracker.sv
module sad_best_tracker #(
  parameter int SAD_W = 16,
  parameter int OFF_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     in_valid,
  input  logic [SAD_W-1:0]         in_sad,
  input  logic signed [OFF_W-1:0]  in_dx,
  input  logic signed [OFF_W-1:0]  in_dy,
  output logic                     best_valid,
  output logic [SAD_W-1:0]         best_sad,
  output logic signed [OFF_W-1:0]  best_dx,
  output logic signed [OFF_W-1:0]  best_dy
);
  logic take_new;
  assign take_new = in_valid && (!best_valid || in_sad < best_sad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_valid <= 1'b0; best_sad <= '0; best_dx <= '0; best_dy <= '0;
    end else if (clear) begin
      best_valid <= 1'b0;
    end else if (take_new) begin
      best_valid <= 1'b1;
      best_sad   <= in_sad;
      best_dx    <= in_dx;
      best_dy    <= in_dy;
    end
  end

  // R9
  best_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (best_valid && !clear) |=> best_sad <= $past(best_sad));
  // R9
  tie_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (best_valid && !clear && in_valid && in_sad == best_sad) |=> $stable(best_dx) && $stable(best_dy));
  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !best_valid);
endmodule

// File: rtl/sad_search_engine.sv
module sad_search_engine
  import sad_pkg::*;
#(
  parameter int N     = 16,
  parameter int PIX_W = 8,
  parameter int OFF_W = 8,
  localparam int ROW_W = N*PIX_W,
  localparam int IDX_W = $clog2(N),
  localparam int SAD_W = PIX_W + 2*$clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cur_wr_en,
  input  logic [IDX_W-1:0]         cur_wr_row,
  input  logic [ROW_W-1:0]         cur_wr_data,
  input  logic                     ref_wr_en,
  input  logic [IDX_W-1:0]         ref_wr_row,
  input  logic [ROW_W-1:0]         ref_wr_data,
  input  logic                     sh_en,
  input  logic [1:0]               sh_dir,
  input  logic [ROW_W-1:0]         sh_fill,
  input  logic                     eval,
  input  logic                     start,
  output logic                     sad_valid,
  output logic [SAD_W-1:0]         sad_value,
  output logic signed [OFF_W-1:0]  sad_dx,
  output logic signed [OFF_W-1:0]  sad_dy,
  output logic                     best_valid,
  output logic [SAD_W-1:0]         best_sad,
  output logic signed [OFF_W-1:0]  best_dx,
  output logic signed [OFF_W-1:0]  best_dy
);
  logic [N*N*PIX_W-1:0]    cur_flat, ref_flat;
  logic signed [OFF_W-1:0] off_dx_q, off_dy_q, base_dx, base_dy;
  shift_dir_t              dir_e;

  assign dir_e   = shift_dir_t'(sh_dir);
  assign base_dx = start ? '0 : off_dx_q;
  assign base_dy = start ? '0 : off_dy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_dx_q <= '0;
      off_dy_q <= '0;
    end else begin
      off_dx_q <= base_dx;
      off_dy_q <= base_dy;
      if (sh_en) begin
        case (dir_e)
          SH_UP:    off_dy_q <= base_dy + OFF_W'(1);
          SH_DOWN:  off_dy_q <= base_dy - OFF_W'(1);
          SH_LEFT:  off_dx_q <= base_dx + OFF_W'(1);
          default:  off_dx_q <= base_dx - OFF_W'(1);
        endcase
      end
    end
  end

  sad_cur_store #(.N(N), .PIX_W(PIX_W)) u_cur (
    .clk(clk), .rst_n(rst_n), .wr_en(cur_wr_en), .wr_row(cur_wr_row),
    .wr_data(cur_wr_data), .pix_flat(cur_flat));

  sad_ref_shifter #(.N(N), .PIX_W(PIX_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .wr_en(ref_wr_en), .wr_row(ref_wr_row),
    .wr_data(ref_wr_data), .sh_en(sh_en), .sh_dir(dir_e), .sh_fill(sh_fill),
    .pix_flat(ref_flat));

  sad_tree #(.N(N), .PIX_W(PIX_W), .OFF_W(OFF_W)) u_tree (
    .clk(clk), .rst_n(rst_n), .eval(eval), .flush(start),
    .cur_flat(cur_flat), .ref_flat(ref_flat), .tag_dx(base_dx), .tag_dy(base_dy),
    .out_valid(sad_valid), .out_sad(sad_value), .out_dx(sad_dx), .out_dy(sad_dy));

  sad_best_tracker #(.SAD_W(SAD_W), .OFF_W(OFF_W)) u_best (
    .clk(clk), .rst_n(rst_n), .clear(start), .in_valid(sad_valid),
    .in_sad(sad_value), .in_dx(sad_dx), .in_dy(sad_dy),
    .best_valid(best_valid), .best_sad(best_sad), .best_dx(best_dx), .best_dy(best_dy));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval ##1 !start |=> sad_valid);
  // R8
  offset_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_en && !start && dir_e == SH_UP) |=> off_dy_q == $past(off_dy_q) + OFF_W'(1));
  // R8
  offset_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_en && !start && dir_e == SH_RIGHT) |=> off_dx_q == $past(off_dx_q) - OFF_W'(1));
  // R8
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sh_en && !start) |=> $stable(off_dx_q) && $stable(off_dy_q));
endmodule

// File: tb/sad_search_engine_tb.sv
module sad_search_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cur_wr_en = 0, ref_wr_en = 0, sh_en = 0, eval = 0, start = 0;
  logic [3:0] cur_wr_row = 0, ref_wr_row = 0;
  logic [127:0] cur_wr_data = 0, ref_wr_data = 0, sh_fill = 0;
  logic [1:0] sh_dir = 0;
  logic sad_valid, best_valid;
  logic [15:0] sad_value, best_sad;
  logic signed [7:0] sad_dx, sad_dy, best_dx, best_dy;

  int n_checks = 0, n_fails = 0;
  int cur_m [16][16];
  int ref_m [16][16];
  int mdx = 0, mdy = 0;

  always #4ns clk = ~clk;

  sad_search_engine u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    cur_wr_en = 0; ref_wr_en = 0; sh_en = 0; eval = 0; start = 0;
  endtask

  function automatic logic [127:0] pack(input int v [16]);
    logic [127:0] p;
    for (int i = 0; i < 16; i++) p[i*8 +: 8] = v[i][7:0];
    return p;
  endfunction

  function automatic int model_sad();
    int s = 0;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        s += (cur_m[r][c] > ref_m[r][c]) ? cur_m[r][c] - ref_m[r][c] : ref_m[r][c] - cur_m[r][c];
    return s;
  endfunction

  task automatic load_all();
    int row [16];
    for (int r = 0; r < 16; r++) begin
      for (int c = 0; c < 16; c++) row[c] = cur_m[r][c];
      cur_wr_en = 1; cur_wr_row = 4'(r); cur_wr_data = pack(row);
      for (int c = 0; c < 16; c++) row[c] = ref_m[r][c];
      ref_wr_en = 1; ref_wr_row = 4'(r); ref_wr_data = pack(row);
      tick();
    end
    idle();
  endtask

  // model shift; the window moves on the data, offset moves in the model
  task automatic model_shift(input int dir, input int fill [16]);
    int t [16][16];
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        case (dir)
          0: t[r][c] = (r == 15) ? fill[c] : ref_m[r+1][c];
          1: t[r][c] = (r == 0)  ? fill[c] : ref_m[r-1][c];
          2: t[r][c] = (c == 15) ? fill[r] : ref_m[r][c+1];
          default: t[r][c] = (c == 0) ? fill[r] : ref_m[r][c-1];
        endcase
      end
    ref_m = t;
    case (dir)
      0: mdy++;
      1: mdy--;
      2: mdx++;
      default: mdx--;
    endcase
  endtask

  task automatic do_shift(input int dir, input int seed);
    int fill [16];
    for (int i = 0; i < 16; i++) fill[i] = (seed * 37 + i * 11 + 3) & 255;
    sh_en = 1; sh_dir = 2'(dir); sh_fill = pack(fill);
    tick();
    idle();
    model_shift(dir, fill);
  endtask

  task automatic eval_check(input string req);
    int e = model_sad();
    eval = 1; tick(); eval = 0; tick();
    check(sad_valid === 1'b1, req, int'(sad_valid), 1);
    check(int'(sad_value) == e, req, int'(sad_value), e);
    check(int'(sad_dx) == mdx && int'(sad_dy) == mdy, {req, " offset"},
          int'(sad_dx) * 1000 + int'(sad_dy), mdx * 1000 + mdy);
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (3) tick(); rst_n = 1; tick();
    check(sad_valid === 1'b0, "R1 sad_valid", int'(sad_valid), 0);
    check(best_valid === 1'b0, "R1 best_valid", int'(best_valid), 0);
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) begin cur_m[r][c] = 0; ref_m[r][c] = 0; end
    eval_check("R1 zero stores");
  endtask

  task automatic t_extremes();
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) begin
      cur_m[r][c] = (r * 29 + c * 13) & 255; ref_m[r][c] = cur_m[r][c];
    end
    load_all(); eval_check("R12 identical");
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) begin
      cur_m[r][c] = 0; ref_m[r][c] = 255;
    end
    load_all(); eval_check("R3 full range");
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) begin
      cur_m[r][c] = (r * 17 + c * 5 + 40) & 255; ref_m[r][c] = (r * 3 + c * 41 + 7) & 255;
    end
    load_all(); eval_check("R2 mixed");
  endtask

  task automatic t_shifts();
    start = 1; tick(); idle(); mdx = 0; mdy = 0;
    do_shift(0, 1); eval_check("R4 up");
    do_shift(1, 2); eval_check("R5 down");
    do_shift(2, 3); eval_check("R6 left");
    do_shift(3, 4); eval_check("R7 right");
    do_shift(0, 5); do_shift(2, 6); do_shift(2, 7); eval_check("R8 combined");
  endtask

  task automatic t_write_during_shift();
    int fill [16];
    for (int i = 0; i < 16; i++) fill[i] = (i * 19 + 5) & 255;
    sh_en = 1; sh_dir = 2'd1; sh_fill = pack(fill);
    ref_wr_en = 1; ref_wr_row = 4'd7; ref_wr_data = {16{8'hAA}};
    tick(); idle();
    model_shift(1, fill);
    eval_check("R11 write ignored");
  endtask

  task automatic t_search();
    int bs = 0, bx = 0, by = 0;
    bit have = 0;
    int dirs [10] = '{2, 2, 0, 3, 0, 1, 3, 2, 0, 2};
    start = 1; tick(); idle(); mdx = 0; mdy = 0;
    for (int k = 0; k < 10; k++) begin
      int fill [16];
      int e = model_sad();
      if (!have || e < bs) begin bs = e; bx = mdx; by = mdy; have = 1; end
      for (int i = 0; i < 16; i++) fill[i] = (k * 53 + i * 29) & 255;
      eval = 1; sh_en = 1; sh_dir = 2'(dirs[k]); sh_fill = pack(fill);
      tick(); idle();
      model_shift(dirs[k], fill);
    end
    repeat (3) tick();
    check(best_valid === 1'b1, "R9 best_valid", int'(best_valid), 1);
    check(int'(best_sad) == bs, "R9 best_sad", int'(best_sad), bs);
    check(int'(best_dx) == bx && int'(best_dy) == by, "R9 best offset",
          int'(best_dx) * 1000 + int'(best_dy), bx * 1000 + by);
  endtask

  task automatic t_tie_and_start();
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) begin
      cur_m[r][c] = 0; ref_m[r][c] = 5;
    end
    load_all();
    start = 1; tick(); idle(); mdx = 0; mdy = 0;
    eval = 1; sh_en = 1; sh_dir = 2'd2; sh_fill = {16{8'd5}}; tick(); idle();
    eval = 1; tick(); idle(); repeat (3) tick();
    check(int'(best_sad) == 1280, "R9 tie sad", int'(best_sad), 1280);
    check(int'(best_dx) == 0, "R9 tie keeps earlier", int'(best_dx), 0);
    // R10: older result in flight when start arrives
    eval = 1; tick(); idle(); start = 1; tick(); idle(); repeat (3) tick();
    check(best_valid === 1'b0, "R10 in-flight dropped", int'(best_valid), 0);
    // R10: eval with start, after offset moved away from zero
    do_shift(2, 9);
    start = 1; eval = 1; tick(); idle(); repeat (2) tick();
    check(best_valid === 1'b1, "R10 eval with start", int'(best_valid), 1);
    check(int'(best_dx) == 0 && int'(best_dy) == 0, "R10 offset zero",
          int'(best_dx) * 1000 + int'(best_dy), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_extremes();
    t_shifts();
    t_write_during_shift();
    t_search();
    t_tie_and_start();
    finish_run();
  end
endmodule